// File: doc/BRIEF.md
# Sprite Pixel Serializer

This block turns the sprite data gathered for one scanline into a stream of sprite pixels. It has a set of sprite slots. During the fetch window before a line, the fetch logic writes each slot with two pattern planes, a small attribute field and a horizontal start position. A write happens for every slot, even when fewer sprites were found, and a write marked invalid leaves that slot transparent.

While the line is drawn, a pixel enable advances every slot once per pixel. Each slot first counts its start position down to zero. It then shifts out one pattern bit pair per pixel, eight in all, and stays transparent after that until it is written again. A priority picker selects the lowest-numbered slot whose current pixel is not transparent. It reports that slot's 2-bit pattern value, its palette and priority bits, an auxiliary attribute bit and the slot index, so that outside logic can detect a hit by slot 0.

Top module: `sprite_serializer`

## Requirements
- R1: During and after reset, until a slot is loaded, every output is zero: spr_pat=0, spr_pal=0, spr_prio=0, spr_aux=0, spr_slot=0.
- R2: A clock edge with load_en=1 writes slot load_slot with load_lo, load_hi, load_attr and load_x, and makes the slot ready to shift 8 pixels. For that slot, a load overrides a pix_en in the same cycle.
- R3: After a load with load_x=N, the slot stays transparent for the first N pixel enables. Each pix_en edge lowers the remaining delay by one. Cycles without pix_en change no output.
- R4: Once the delay reaches zero, the slot shows one bit pair per pixel enable, taking the most significant bit first. spr_pat[1] comes from the load_hi plane and spr_pat[0] from the load_lo plane.
- R5: Attribute bit 3 is horizontal flip. When it is set, the bits are shown least significant bit first.
- R6: After its 8 bit pairs, a slot shows transparent (pattern 0) until it is loaded again.
- R7: A load with load_valid=0 leaves the slot transparent for the whole line, whatever the pattern inputs carry.
- R8: When several slots show a non-zero pattern, the lowest-numbered one wins. Transparent pixels of lower slots do not hide higher slots.
- R9: The winner's attribute bits drive spr_pal = attr[1:0], spr_prio = attr[2] and spr_aux = attr[4], and its index drives spr_slot. When spr_pat is 0, all of these are 0.
- R10: Outputs are taken from registered state with no extra stage. The effect of a pix_en or load edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | One pixel is drawn this cycle |
| load_en | input | 1 | Write a slot this cycle |
| load_slot | input | 3 | Slot index to write |
| load_valid | input | 1 | 1: real sprite, 0: unused slot (transparent) |
| load_lo | input | 8 | Low pattern plane |
| load_hi | input | 8 | High pattern plane |
| load_attr | input | 5 | [1:0] palette, [2] priority, [3] horizontal flip, [4] auxiliary |
| load_x | input | 8 | Pixel delay before shifting starts |
| spr_pat | output | 2 | Winning 2-bit pattern value (0 = transparent) |
| spr_pal | output | 2 | Winner palette bits |
| spr_prio | output | 1 | Winner priority bit |
| spr_aux | output | 1 | Winner auxiliary bit |
| spr_slot | output | 3 | Winning slot index |

## Verification
A single sprite at a nonzero delay, with asymmetric planes, shows whether the delay is off by one. It also shows that the planes are in order and that the slot goes dark after its eighth pixel. The same pattern with the flip bit set separates MSB-first from LSB-first shifting. Overlapping sprites at the same start position check the priority order, including a lower slot that is transparent in places. Other runs cover invalid loads, gaps in pix_en, and a load that arrives together with a pixel enable; these expose hold and override errors. A behavioural model in the bench tracks every slot and is compared with the outputs on each clock.

// File: rtl/spr_ser_pkg.sv
package spr_ser_pkg;
  localparam int ATTR_W = 5;

  // field layout of the attribute input
  typedef struct packed {
    logic       aux;
    logic       hflip;
    logic       prio;
    logic [1:0] pal;
  } spr_attr_t;

  // what a slot passes on to the picker
  typedef struct packed {
    logic       aux;
    logic       prio;
    logic [1:0] pal;
  } spr_info_t;
endpackage

// File: rtl/spr_slot.sv
module spr_slot
  import spr_ser_pkg::*;
#(
  parameter int PAT_W = 8,
  parameter int X_W   = 8,
  localparam int CNT_W = $clog2(PAT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic             ld_valid,
  input  logic [PAT_W-1:0] ld_lo,
  input  logic [PAT_W-1:0] ld_hi,
  input  spr_attr_t        ld_attr,
  input  logic [X_W-1:0]   ld_x,
  input  logic             pix_en,
  output logic [1:0]       pix,
  output spr_info_t        info
);

  logic [PAT_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [X_W-1:0]   dly_q, dly_d;
  logic [CNT_W-1:0] left_q, left_d;
  spr_info_t        info_q, info_d;
  logic             upd;

  function automatic logic [PAT_W-1:0] mirror(input logic [PAT_W-1:0] v);
    logic [PAT_W-1:0] r;
    for (int i = 0; i < PAT_W; i++) r[i] = v[PAT_W-1-i];
    return r;
  endfunction

  assign upd = ld_en | pix_en;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    dly_d  = dly_q;
    left_d = left_q;
    info_d = info_q;
    if (ld_en) begin
      if (ld_valid) begin
        lo_d = ld_attr.hflip ? mirror(ld_lo) : ld_lo;
        hi_d = ld_attr.hflip ? mirror(ld_hi) : ld_hi;
      end else begin
        lo_d = '0;
        hi_d = '0;
      end
      dly_d  = ld_x;
      left_d = CNT_W'(PAT_W);
      info_d = '{aux: ld_attr.aux, prio: ld_attr.prio, pal: ld_attr.pal};
    end else if (pix_en) begin
      if (dly_q != '0) begin
        dly_d = dly_q - 1'b1;
      end else if (left_q != '0) begin
        lo_d   = lo_q << 1;
        hi_d   = hi_q << 1;
        left_d = left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      dly_q  <= '0;
      left_q <= '0;
      info_q <= '0;
    end else if (upd) begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      dly_q  <= dly_d;
      left_q <= left_d;
      info_q <= info_d;
    end
  end

  assign pix  = (dly_q == '0 && left_q != '0) ? {hi_q[PAT_W-1], lo_q[PAT_W-1]} : 2'b00;
  assign info = info_q;

endmodule

// File: rtl/spr_pick.sv
module spr_pick
  import spr_ser_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0][1:0] pix_all,
  input  spr_info_t [NUM_SLOTS-1:0] info_all,
  output logic [1:0]                win_pat,
  output spr_info_t                 win_info,
  output logic [SLOT_W-1:0]         win_slot
);

  // scan from the top so the lowest opaque index is the last to write
  always_comb begin
    win_pat  = 2'b00;
    win_info = '0;
    win_slot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (pix_all[i] != 2'b00) begin
        win_pat  = pix_all[i];
        win_info = info_all[i];
        win_slot = SLOT_W'(i);
      end
    end
  end

endmodule

// File: rtl/sprite_serializer.sv
module sprite_serializer
  import spr_ser_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int PAT_W     = 8,
  parameter int X_W       = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              load_en,
  input  logic [SLOT_W-1:0] load_slot,
  input  logic              load_valid,
  input  logic [PAT_W-1:0]  load_lo,
  input  logic [PAT_W-1:0]  load_hi,
  input  logic [ATTR_W-1:0] load_attr,
  input  logic [X_W-1:0]    load_x,
  output logic [1:0]        spr_pat,
  output logic [1:0]        spr_pal,
  output logic              spr_prio,
  output logic              spr_aux,
  output logic [SLOT_W-1:0] spr_slot
);

  logic [NUM_SLOTS-1:0][1:0] pix_all;
  spr_info_t [NUM_SLOTS-1:0] info_all;
  spr_info_t                 win_info;
  spr_attr_t                 attr_in;

  assign attr_in = spr_attr_t'(load_attr);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic sel;
    assign sel = load_en && (load_slot == SLOT_W'(g));
    spr_slot #(.PAT_W(PAT_W), .X_W(X_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (sel),
      .ld_valid (load_valid),
      .ld_lo    (load_lo),
      .ld_hi    (load_hi),
      .ld_attr  (attr_in),
      .ld_x     (load_x),
      .pix_en   (pix_en),
      .pix      (pix_all[g]),
      .info     (info_all[g])
    );
  end

  spr_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .pix_all  (pix_all),
    .info_all (info_all),
    .win_pat  (spr_pat),
    .win_info (win_info),
    .win_slot (spr_slot)
  );

  assign spr_pal  = win_info.pal;
  assign spr_prio = win_info.prio;
  assign spr_aux  = win_info.aux;

endmodule

// File: rtl/sprite_serializer_chk.sv
module sprite_serializer_chk
  import spr_ser_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int PAT_W     = 8,
  parameter int X_W       = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_en,
  input logic              load_en,
  input logic [SLOT_W-1:0] load_slot,
  input logic              load_valid,
  input logic [PAT_W-1:0]  load_lo,
  input logic [PAT_W-1:0]  load_hi,
  input logic [ATTR_W-1:0] load_attr,
  input logic [X_W-1:0]    load_x,
  input logic [1:0]        spr_pat,
  input logic [1:0]        spr_pal,
  input logic              spr_prio,
  input logic              spr_aux,
  input logic [SLOT_W-1:0] spr_slot
);

  logic seen_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      seen_load <= 1'b0;
    else if (load_en && load_valid)  seen_load <= 1'b1;
  end

  a_r1_dark_until_load: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_pat != 2'b00) |-> seen_load);

  a_r9_zero_fields_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_pat == 2'b00) |-> (spr_pal == 2'b00 && !spr_prio && !spr_aux && spr_slot == '0));

  a_r3_hold_without_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !load_en) |=> ($stable(spr_pat) && $stable(spr_pal) && $stable(spr_prio)
                               && $stable(spr_aux) && $stable(spr_slot)));

  a_r10_outputs_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({spr_pat, spr_pal, spr_prio, spr_aux, spr_slot}));

endmodule

bind sprite_serializer sprite_serializer_chk #(
  .NUM_SLOTS(NUM_SLOTS), .PAT_W(PAT_W), .X_W(X_W)
) u_chk (.*);

// File: tb/sprite_serializer_bench.sv
module sprite_serializer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0;
  logic       load_en = 1'b0;
  logic [2:0] load_slot = '0;
  logic       load_valid = 1'b0;
  logic [7:0] load_lo = '0, load_hi = '0, load_x = '0;
  logic [4:0] load_attr = '0;
  logic [1:0] spr_pat, spr_pal;
  logic       spr_prio, spr_aux;
  logic [2:0] spr_slot;

  int total = 0;
  int bad = 0;

  // behavioural model state
  int m_dly[8], m_lo[8], m_hi[8], m_attr[8], m_left[8];

  always #5 clk = ~clk;

  sprite_serializer u_sprite_serializer (
    .clk, .rst_n, .pix_en, .load_en, .load_slot, .load_valid,
    .load_lo, .load_hi, .load_attr, .load_x,
    .spr_pat, .spr_pal, .spr_prio, .spr_aux, .spr_slot
  );

  task automatic model_clear();
    for (int s = 0; s < 8; s++) begin
      m_dly[s] = 0; m_lo[s] = 0; m_hi[s] = 0; m_attr[s] = 0; m_left[s] = 0;
    end
  endtask

  task automatic model_edge();
    for (int s = 0; s < 8; s++) begin
      if (load_en && int'(load_slot) == s) begin
        m_lo[s]   = load_valid ? int'(load_lo) : 0;
        m_hi[s]   = load_valid ? int'(load_hi) : 0;
        m_attr[s] = int'(load_attr);
        m_dly[s]  = int'(load_x);
        m_left[s] = 8;
      end else if (pix_en) begin
        if (m_dly[s] > 0) m_dly[s]--;
        else if (m_left[s] > 0) m_left[s]--;
      end
    end
  endtask

  task automatic check(input string tag);
    int ep, epal, eprio, eaux, eslot;
    ep = 0; epal = 0; eprio = 0; eaux = 0; eslot = 0;
    for (int s = 0; s < 8; s++) begin
      if (ep == 0 && m_dly[s] == 0 && m_left[s] > 0) begin
        int pos, p;
        pos = 8 - m_left[s];
        if (((m_attr[s] >> 3) & 1) == 0) pos = 7 - pos;
        p = (((m_hi[s] >> pos) & 1) << 1) | ((m_lo[s] >> pos) & 1);
        if (p != 0) begin
          ep = p; epal = m_attr[s] & 3; eprio = (m_attr[s] >> 2) & 1;
          eaux = (m_attr[s] >> 4) & 1; eslot = s;
        end
      end
    end
    total++;
    if (int'(spr_pat) != ep || int'(spr_pal) != epal || int'(spr_prio) != eprio ||
        int'(spr_aux) != eaux || int'(spr_slot) != eslot) begin
      bad++;
      $display("FAIL %s: got pat=%0d pal=%0d prio=%0d aux=%0d slot=%0d exp pat=%0d pal=%0d prio=%0d aux=%0d slot=%0d",
               tag, spr_pat, spr_pal, spr_prio, spr_aux, spr_slot, ep, epal, eprio, eaux, eslot);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    if (rst_n) model_edge();
    else model_clear();
    @(negedge clk);
    check(tag);
  endtask

  task automatic load(input int slot, input bit valid, input logic [7:0] lo, input logic [7:0] hi,
                      input logic [4:0] attr, input logic [7:0] x, input string tag);
    load_en = 1'b1; load_slot = 3'(slot); load_valid = valid;
    load_lo = lo; load_hi = hi; load_attr = attr; load_x = x;
    step(tag);
    load_en = 1'b0; load_valid = 1'b0;
  endtask

  task automatic pixels(input int n, input string tag);
    pix_en = 1'b1;
    for (int i = 0; i < n; i++) step(tag);
    pix_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_clear();
    @(negedge clk);
    check("R1 in reset");
    step("R1 in reset");
    rst_n = 1'b1;
    step("R1 after reset");
    pixels(3, "R1 pixels with nothing loaded");

    // single sprite, delay 3, asymmetric planes, pal=2 prio=1 aux=1
    load(0, 1'b1, 8'b1010_0011, 8'b0110_0001, 5'b1_0_1_10, 8'd3, "R2 load slot0");
    step("R3 idle hold");
    pixels(3, "R3 delay");
    pixels(8, "R4 R9 shift msb first");
    pixels(3, "R6 dark after eight");

    // horizontal flip on slot 1
    load(1, 1'b1, 8'b1000_0011, 8'b0000_0110, 5'b0_1_0_01, 8'd1, "R2 load slot1");
    pixels(1, "R3 delay flip");
    pixels(4, "R5 flip lsb first");
    step("R3 gap");
    pixels(5, "R5 R6 flip tail");

    // invalid load ignores pattern inputs
    load(2, 1'b0, 8'hFF, 8'hFF, 5'b1_0_1_11, 8'd0, "R7 invalid load");
    pixels(9, "R7 stays transparent");

    // overlap: slot 2 partly transparent, slot 5 solid
    load(5, 1'b1, 8'hFF, 8'hFF, 5'b0_0_0_11, 8'd0, "R2 load slot5");
    load(2, 1'b1, 8'b1100_1100, 8'b0000_0000, 5'b1_0_1_01, 8'd0, "R2 load slot2");
    pixels(9, "R8 lowest wins");

    // load and pixel in the same cycle: load wins for that slot
    load(3, 1'b1, 8'hF0, 8'h0F, 5'b0_0_0_10, 8'd0, "R2 preload slot3");
    pixels(2, "R4 slot3 run");
    pix_en = 1'b1;
    load(3, 1'b1, 8'b1001_0110, 8'b0101_1010, 5'b1_0_0_00, 8'd2, "R2 load beats pixel");
    pixels(11, "R2 R3 reload run");

    // all eight slots
    for (int s = 0; s < 8; s++)
      load(s, (s != 4), 8'(8'h11 * (s + 1)), 8'(8'h35 ^ (s * 29)), 5'(s * 7), 8'(s * 2), "R8 fill all");
    for (int k = 0; k < 12; k++) begin
      pixels(2, "R8 R4 all slots");
      step("R3 all slots gap");
    end
    pixels(4, "R6 all drained");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule